// File: doc/BRIEF.md
# TLB Lookup with Ring-Based Protection

This block translates a 32-bit virtual address into a physical address for one access at a time. It keeps two translation arrays: one serves instruction fetches, the other serves loads and stores. Each array has seven ways with four entries per way. Every way has its own fixed page size. An access indexes every way of the selected array in parallel and compares the page tags. Each candidate's address-space identifier is then turned into a protection ring by searching a 32-bit ring-ID register. The result is either a physical address or a fault cause.

Requests enter on a valid/ready channel and results leave on another valid/ready channel, with one pipeline register between them. A result that is not taken stays on the output unchanged, and no new request is accepted while it waits. If the consumer takes the result in the same cycle, a new request can be accepted in that cycle. Writes to entries and to the ring-ID register are plain single-cycle register writes. Refilling entries from page tables is done elsewhere.

Top module: `tlbr_lookup`

## Requirements
- R1: A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Its result appears with `rsp_valid` high after the next clock edge. `req_ready` is high whenever `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the result holds its cause and address unchanged.
- R2: The ring-ID register holds four 8-bit identifiers: bits 7:0 for ring 0, 15:8 for ring 1, 23:16 for ring 2 and 31:24 for ring 3. A candidate entry takes the lowest ring whose byte equals its identifier. An entry whose identifier is in no byte does not hit.
- R3: An entry whose identifier is 0 never hits, even when a byte of the ring-ID register is 0.
- R4: If two or more ways hit, the cause is 2 for an execute access and 6 for a read or write access.
- R5: If no way hits, the cause is 1 for an execute access and 5 for a read or write access.
- R6: If exactly one way hits and its ring is lower than `req_ring`, the cause is 3 for an execute access and 7 for a read or write access. This check takes precedence over the attribute check.
- R7: Attribute decode works as follows. For values 0 to 11, read is allowed; bit 0 adds execute and bit 1 adds write. Value 13 allows read and write. All other values allow nothing. A denied access gives cause 4 for execute, 9 for write and 8 for read. Access code 3 is reserved and is denied as a read.
- R8: A permitted access gives cause 0. Its address is the entry's physical page ORed with the virtual-address bits below the way's page size. Page sizes are 4 KiB for ways 0 to 3, 1 MiB for way 4, 128 MiB for way 5 and 256 MiB for way 6. The entry index is the two address bits just above the page offset. Any fault returns address 0.
- R9: After reset the ring-ID register is 0x04030201, and every entry has identifier 0 except four entries in each array, all with identifier 1. In way 5, 0xD0000000 maps to physical 0 with attribute 7, and 0xD8000000 maps to physical 0 with attribute 3. In way 6, 0xE0000000 maps to 0xF0000000 with attribute 7, and 0xF0000000 maps to 0xF0000000 with attribute 3.
- R10: Access code 2 (execute) looks up the instruction array. Codes 0 (read), 1 (write) and 3 look up the data array. An entry write goes to the data array when `wr_dside` is 1 and to the instruction array otherwise.
- R11: An entry write or ring-ID write in the same cycle as an accepted request does not affect that request. The request sees the contents from before the write. The write takes effect for requests accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_ring | input | 2 | Current privilege ring |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_cause | output | 4 | Fault cause, 0 when permitted |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| wr_en | input | 1 | Entry write strobe |
| wr_dside | input | 1 | 1 selects the data array, 0 the instruction array |
| wr_way | input | 3 | Way written (0 to 6) |
| wr_idx | input | 2 | Entry index within the way |
| wr_vpn | input | 32 | Virtual page tag of the entry |
| wr_ppn | input | 32 | Physical page of the entry |
| wr_asid | input | 8 | Address-space identifier of the entry |
| wr_attr | input | 4 | Attribute code of the entry |
| rasid_we | input | 1 | Ring-ID register write strobe |
| rasid_wdata | input | 32 | New ring-ID register value |

## Verification
Two things can happen in the same cycle: a lookup can be accepted while an entry or the ring-ID register is being written. The bench provokes this in two ways. A directed case writes the very entry, or the ring-ID byte, that the request would hit. A long random phase also raises both strobes together on a small pool of addresses. The behavioural model in the bench resolves every accepted lookup against its state before it applies that cycle's writes, and it compares the DUT's result on every clock. A response stalled by `rsp_ready` low while writes continue must still show the pre-write result.

// File: rtl/tlbr_pkg.sv
`timescale 1ns/1ps
package tlbr_pkg;
  localparam int ADDR_W    = 32;
  localparam int ASID_W    = 8;
  localparam int ATTR_W    = 4;
  localparam int RING_W    = 2;
  localparam int NUM_RINGS = 1 << RING_W;
  localparam int NUM_WAYS  = 7;
  localparam int WAY_W     = $clog2(NUM_WAYS);
  localparam int FIX_WAY_A = 5;
  localparam int FIX_WAY_B = 6;
  localparam logic [NUM_RINGS*ASID_W-1:0] RING_ID_RESET = 32'h0403_0201;

  typedef struct packed {
    logic [ADDR_W-1:0] vpn;
    logic [ADDR_W-1:0] ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [3:0] {
    C_OK           = 4'd0,
    C_I_MISS       = 4'd1,
    C_I_MULTI      = 4'd2,
    C_I_PRIV       = 4'd3,
    C_FETCH_PROHIB = 4'd4,
    C_D_MISS       = 4'd5,
    C_D_MULTI      = 4'd6,
    C_D_PRIV       = 4'd7,
    C_LOAD_PROHIB  = 4'd8,
    C_STORE_PROHIB = 4'd9
  } cause_e;

  // Page offset width for each way.
  function automatic int page_shift(input int way);
    if (way < 4)       return 12;
    else if (way == 4) return 20;
    else if (way == 5) return 27;
    else               return 28;
  endfunction

  function automatic logic [ADDR_W-1:0] page_mask(input int way);
    return {ADDR_W{1'b1}} << page_shift(way);
  endfunction
endpackage

// File: rtl/tlbr_array.sv
`timescale 1ns/1ps
module tlbr_array
  import tlbr_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [IDX_W-1:0]            wr_idx,
  input  tlb_entry_t                  wr_entry,
  input  logic [ADDR_W-1:0]           lk_vaddr,
  output tlb_entry_t [NUM_WAYS-1:0]   cand
);
  localparam int ENTRIES = 1 << IDX_W;

  tlb_entry_t mem [NUM_WAYS][ENTRIES];

  function automatic int idx_of(input logic [ADDR_W-1:0] va, input int way);
    logic [ADDR_W-1:0] s;
    s = va >> page_shift(way);
    return int'(s[IDX_W-1:0]);
  endfunction

  function automatic tlb_entry_t fixed_entry(input logic [ADDR_W-1:0] va,
                                             input logic [ADDR_W-1:0] pa,
                                             input logic [ATTR_W-1:0] at);
    tlb_entry_t r;
    r.vpn  = va;
    r.ppn  = pa;
    r.asid = ASID_W'(1);
    r.attr = at;
    return r;
  endfunction

  // Reset image: variable entries invalid, four static mappings.
  function automatic tlb_entry_t reset_entry(input int way, input int ent);
    tlb_entry_t r;
    r = '0;
    if (way == FIX_WAY_A) begin
      if (ent == idx_of(32'hD000_0000, way))
        r = fixed_entry(32'hD000_0000, 32'h0000_0000, 4'd7);
      else if (ent == idx_of(32'hD800_0000, way))
        r = fixed_entry(32'hD800_0000, 32'h0000_0000, 4'd3);
    end else if (way == FIX_WAY_B) begin
      if (ent == idx_of(32'hE000_0000, way))
        r = fixed_entry(32'hE000_0000, 32'hF000_0000, 4'd7);
      else if (ent == idx_of(32'hF000_0000, way))
        r = fixed_entry(32'hF000_0000, 32'hF000_0000, 4'd3);
    end
    return r;
  endfunction

  logic way_ok;
  assign way_ok = int'(wr_way) < NUM_WAYS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++)
        for (int e = 0; e < ENTRIES; e++)
          mem[w][e] <= reset_entry(w, e);
    end else if (wr_en && way_ok) begin
      mem[wr_way][wr_idx] <= wr_entry;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
    localparam int SH = page_shift(w);
    assign cand[w] = mem[w][lk_vaddr[SH +: IDX_W]];
  end

  // R11: a write is visible from the following cycle on.
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && way_ok) |=> (mem[$past(wr_way)][$past(wr_idx)] == $past(wr_entry)));
endmodule

// File: rtl/tlbr_ring_map.sv
`timescale 1ns/1ps
module tlbr_ring_map
  import tlbr_pkg::*;
(
  input  logic [ADDR_W-1:0]                   vaddr,
  input  logic [NUM_RINGS*ASID_W-1:0]         ring_ids,
  input  tlb_entry_t [NUM_WAYS-1:0]           cand,
  output logic [NUM_WAYS-1:0]                 hit,
  output logic [NUM_WAYS-1:0][RING_W-1:0]     ring
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam logic [ADDR_W-1:0] MASK = page_mask(w);
    logic              tag_eq;
    logic              found;
    logic [RING_W-1:0] rg;

    always_comb begin
      tag_eq = ((vaddr ^ cand[w].vpn) & MASK) == '0;
      found  = 1'b0;
      rg     = '0;
      // Scan from the top so the lowest matching byte wins.
      for (int r = NUM_RINGS - 1; r >= 0; r--) begin
        if (ring_ids[r*ASID_W +: ASID_W] == cand[w].asid) begin
          found = 1'b1;
          rg    = RING_W'(r);
        end
      end
    end

    assign hit[w]  = tag_eq && (cand[w].asid != '0) && found;
    assign ring[w] = rg;
  end
endmodule

// File: rtl/tlbr_resolve.sv
`timescale 1ns/1ps
module tlbr_resolve
  import tlbr_pkg::*;
(
  input  logic [ADDR_W-1:0]               vaddr,
  input  access_e                         access,
  input  logic [RING_W-1:0]               cur_ring,
  input  logic [NUM_WAYS-1:0]             hit,
  input  logic [NUM_WAYS-1:0][RING_W-1:0] ring,
  input  tlb_entry_t [NUM_WAYS-1:0]       cand,
  output cause_e                          cause,
  output logic [ADDR_W-1:0]               paddr
);
  logic [ATTR_W-1:0] sel_attr;
  logic [RING_W-1:0] sel_ring;
  logic [ADDR_W-1:0] sel_pa;
  int                nhit;
  logic              can_rd, can_wr, can_ex, granted, is_i;

  always_comb begin
    sel_attr = '0;
    sel_ring = '0;
    sel_pa   = '0;
    nhit     = 0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit[w]) begin
        nhit     = nhit + 1;
        sel_attr = sel_attr | cand[w].attr;
        sel_ring = sel_ring | ring[w];
        sel_pa   = sel_pa | cand[w].ppn | (vaddr & ~page_mask(w));
      end
    end
  end

  always_comb begin
    can_rd = (sel_attr < 4'd12) || (sel_attr == 4'd13);
    can_wr = ((sel_attr < 4'd12) && sel_attr[1]) || (sel_attr == 4'd13);
    can_ex = (sel_attr < 4'd12) && sel_attr[0];
    unique case (access)
      ACC_READ:  granted = can_rd;
      ACC_WRITE: granted = can_wr;
      ACC_EXEC:  granted = can_ex;
      default:   granted = 1'b0;
    endcase
  end

  assign is_i = (access == ACC_EXEC);

  always_comb begin
    if (nhit > 1)
      cause = is_i ? C_I_MULTI : C_D_MULTI;
    else if (nhit == 0)
      cause = is_i ? C_I_MISS : C_D_MISS;
    else if (sel_ring < cur_ring)
      cause = is_i ? C_I_PRIV : C_D_PRIV;
    else if (!granted)
      cause = is_i ? C_FETCH_PROHIB :
              (access == ACC_WRITE) ? C_STORE_PROHIB : C_LOAD_PROHIB;
    else
      cause = C_OK;
  end

  assign paddr = (cause == C_OK) ? sel_pa : '0;
endmodule

// File: rtl/tlbr_lookup.sv
`timescale 1ns/1ps
module tlbr_lookup
  import tlbr_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [1:0]        req_access,
  input  logic [1:0]        req_ring,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [3:0]        rsp_cause,
  output logic [31:0]       rsp_paddr,
  input  logic              wr_en,
  input  logic              wr_dside,
  input  logic [2:0]        wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_vpn,
  input  logic [31:0]       wr_ppn,
  input  logic [7:0]        wr_asid,
  input  logic [3:0]        wr_attr,
  input  logic              rasid_we,
  input  logic [31:0]       rasid_wdata
);
  localparam int NUM_SIDES = 2;   // 0 instruction, 1 data

  logic [NUM_RINGS*ASID_W-1:0]          ring_ids;
  tlb_entry_t                           wr_entry;
  tlb_entry_t [NUM_SIDES-1:0][NUM_WAYS-1:0] cand_s;
  tlb_entry_t [NUM_WAYS-1:0]            cand;
  logic [NUM_WAYS-1:0]                  way_hit;
  logic [NUM_WAYS-1:0][RING_W-1:0]      way_ring;
  access_e                              acc;
  cause_e                               res_cause;
  logic [ADDR_W-1:0]                    res_paddr;
  logic                                 accept;
  cause_e                               cause_q;

  assign acc = access_e'(req_access);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ring_ids <= RING_ID_RESET;
    else if (rasid_we) ring_ids <= rasid_wdata;
  end

  assign wr_entry.vpn  = wr_vpn;
  assign wr_entry.ppn  = wr_ppn;
  assign wr_entry.asid = wr_asid;
  assign wr_entry.attr = wr_attr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    tlbr_array #(.IDX_W(IDX_W)) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_dside == 1'(s))),
      .wr_way   (wr_way),
      .wr_idx   (wr_idx),
      .wr_entry (wr_entry),
      .lk_vaddr (req_vaddr),
      .cand     (cand_s[s])
    );
  end

  assign cand = (acc == ACC_EXEC) ? cand_s[0] : cand_s[1];

  tlbr_ring_map u_ring (
    .vaddr    (req_vaddr),
    .ring_ids (ring_ids),
    .cand     (cand),
    .hit      (way_hit),
    .ring     (way_ring)
  );

  tlbr_resolve u_res (
    .vaddr    (req_vaddr),
    .access   (acc),
    .cur_ring (req_ring),
    .hit      (way_hit),
    .ring     (way_ring),
    .cand     (cand),
    .cause    (res_cause),
    .paddr    (res_paddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      cause_q   <= C_OK;
      rsp_paddr <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      cause_q   <= res_cause;
      rsp_paddr <= res_paddr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_cause = cause_q;

  // R1: an accepted request always yields a result next cycle.
  p_accept_gives_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R1: a stalled result does not move.
  p_stall_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_paddr)));

  // R4: a permitted translation comes from exactly one way.
  p_ok_single_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && res_cause == C_OK) |-> ($countones(way_hit) == 1));

  // R8: faults carry no address.
  p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != C_OK) |-> (rsp_paddr == '0));

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
    // R3: identifier 0 never produces a hit.
    p_asid0_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && way_hit[w]) |-> (cand[w].asid != '0));
  end
endmodule

// File: tb/tlbr_lookup_tb.sv
`timescale 1ns/1ps
module tlbr_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_access = '0;
  logic [1:0]  req_ring = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic        wr_en = 1'b0;
  logic        wr_dside = 1'b0;
  logic [2:0]  wr_way = '0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0;
  logic [31:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic        rasid_we = 1'b0;
  logic [31:0] rasid_wdata = '0;

  always #5 clk = ~clk;

  tlbr_lookup u_dut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string ctx = "R9 reset";

  // Behavioural reference state.
  logic [31:0] m_vpn  [2][7][4];
  logic [31:0] m_ppn  [2][7][4];
  logic [7:0]  m_asid [2][7][4];
  logic [3:0]  m_attr [2][7][4];
  logic [31:0] m_ids;
  bit          m_v;
  logic [3:0]  m_c;
  logic [31:0] m_pa;

  function automatic int bshift(input int w);
    case (w)
      0, 1, 2, 3: return 12;
      4:          return 20;
      5:          return 27;
      default:    return 28;
    endcase
  endfunction

  function automatic int ent_of(input logic [31:0] va, input int w);
    return int'((va >> bshift(w)) & 32'd3);
  endfunction

  task automatic put(input int s, input int w, input logic [31:0] va,
                     input logic [31:0] pa, input logic [3:0] at);
    int e;
    e = ent_of(va, w);
    m_vpn[s][w][e] = va; m_ppn[s][w][e] = pa;
    m_asid[s][w][e] = 8'd1; m_attr[s][w][e] = at;
  endtask

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 7; w++)
        for (int e = 0; e < 4; e++) begin
          m_vpn[s][w][e] = '0; m_ppn[s][w][e] = '0;
          m_asid[s][w][e] = '0; m_attr[s][w][e] = '0;
        end
    for (int s = 0; s < 2; s++) begin
      put(s, 5, 32'hD000_0000, 32'h0, 4'd7);
      put(s, 5, 32'hD800_0000, 32'h0, 4'd3);
      put(s, 6, 32'hE000_0000, 32'hF000_0000, 4'd7);
      put(s, 6, 32'hF000_0000, 32'hF000_0000, 4'd3);
    end
    m_ids = 32'h0403_0201;
    m_v = 0; m_c = '0; m_pa = '0;
  endtask

  task automatic model_lookup(input logic [31:0] va, input logic [1:0] ac,
                              input logic [1:0] rg, output logic [3:0] c,
                              output logic [31:0] pa);
    int s, nh, hring, e, sh;
    logic [3:0] hattr;
    logic [31:0] hpa;
    bit rd, wr, ex, ok, isx;
    s = (ac == 2'd2) ? 0 : 1;
    isx = (ac == 2'd2);
    nh = 0; hring = 0; hattr = '0; hpa = '0;
    for (int w = 0; w < 7; w++) begin
      sh = bshift(w);
      e = ent_of(va, w);
      if ((va >> sh) == (m_vpn[s][w][e] >> sh) && m_asid[s][w][e] != 0) begin
        int r;
        r = -1;
        for (int b = 0; b < 4; b++)
          if (r < 0 && m_ids[b*8 +: 8] == m_asid[s][w][e]) r = b;
        if (r >= 0) begin
          nh++;
          hring = r;
          hattr = m_attr[s][w][e];
          hpa = m_ppn[s][w][e] | (va & ((32'd1 << sh) - 32'd1));
        end
      end
    end
    rd = (hattr < 12) || (hattr == 13);
    wr = ((hattr < 12) && hattr[1]) || (hattr == 13);
    ex = (hattr < 12) && hattr[0];
    ok = (ac == 0) ? rd : (ac == 1) ? wr : (ac == 2) ? ex : 1'b0;
    pa = '0;
    if (nh > 1)                c = isx ? 4'd2 : 4'd6;
    else if (nh == 0)          c = isx ? 4'd1 : 4'd5;
    else if (hring < int'(rg)) c = isx ? 4'd3 : 4'd7;
    else if (!ok)              c = isx ? 4'd4 : (ac == 1) ? 4'd9 : 4'd8;
    else begin c = 4'd0; pa = hpa; end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0:       return "R8";
      4'd1, 4'd5: return "R5";
      4'd2, 4'd6: return "R4";
      4'd3, 4'd7: return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s [%s] %s: actual=%h expected=%h", tag, ctx, what, act, exp);
    end
  endtask

  // One clock: predict, advance, compare.
  task automatic tick();
    bit rdy;
    logic [3:0] c;
    logic [31:0] pa;
    #1;
    rdy = !m_v || rsp_ready;
    chk(req_ready == rdy, "R1", "req_ready", {31'd0, req_ready}, {31'd0, rdy});
    if (req_valid && rdy) begin
      model_lookup(req_vaddr, req_access, req_ring, c, pa);
      m_v = 1; m_c = c; m_pa = pa;
    end else if (rsp_ready) m_v = 0;
    if (wr_en) begin
      int s;
      s = wr_dside ? 1 : 0;
      if (wr_way < 7) begin
        m_vpn[s][wr_way][wr_idx] = wr_vpn; m_ppn[s][wr_way][wr_idx] = wr_ppn;
        m_asid[s][wr_way][wr_idx] = wr_asid; m_attr[s][wr_way][wr_idx] = wr_attr;
      end
    end
    if (rasid_we) m_ids = rasid_wdata;
    @(posedge clk);
    #1;
    chk(rsp_valid == m_v, "R1", "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_v});
    if (m_v) begin
      chk(rsp_cause == m_c, tag_of(m_c), "rsp_cause", {28'd0, rsp_cause}, {28'd0, m_c});
      chk(rsp_paddr == m_pa, tag_of(m_c), "rsp_paddr", rsp_paddr, m_pa);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] ac, input logic [1:0] rg);
    req_valid = 1; req_vaddr = va; req_access = ac; req_ring = rg; rsp_ready = 1;
    tick();
    req_valid = 0;
  endtask

  task automatic wr_set(input bit d, input int w, input logic [31:0] va,
                        input logic [31:0] pa, input logic [7:0] as, input logic [3:0] at);
    wr_en = 1; wr_dside = d; wr_way = 3'(w); wr_idx = 2'(ent_of(va, w));
    wr_vpn = va; wr_ppn = pa; wr_asid = as; wr_attr = at;
  endtask

  task automatic write(input bit d, input int w, input logic [31:0] va,
                       input logic [31:0] pa, input logic [7:0] as, input logic [3:0] at);
    wr_set(d, w, va, pa, as, at);
    tick();
    wr_en = 0;
  endtask

  task automatic set_ids(input logic [31:0] v);
    rasid_we = 1; rasid_wdata = v;
    tick();
    rasid_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [31:0] pool [8];

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(req_ready == 1'b1, "R9", "reset req_ready", {31'd0, req_ready}, 32'd1);

    ctx = "R9 reset mappings";
    lookup(32'hD000_1234, 2'd2, 2'd0);   // exec, attr 7
    chk(rsp_paddr == 32'h0000_1234, "R9", "fixed way5 paddr", rsp_paddr, 32'h0000_1234);
    lookup(32'hD800_0010, 2'd0, 2'd0);
    lookup(32'hD800_0010, 2'd1, 2'd0);   // attr 3 allows write
    lookup(32'hE000_0100, 2'd1, 2'd0);
    chk(rsp_paddr == 32'hF000_0100, "R9", "fixed way6 paddr", rsp_paddr, 32'hF000_0100);
    lookup(32'hF123_4567, 2'd0, 2'd0);
    lookup(32'h0000_5000, 2'd0, 2'd0);   // empty region: miss
    chk(rsp_cause == 4'd5, "R5", "data miss", {28'd0, rsp_cause}, 32'd5);
    lookup(32'h0000_5000, 2'd2, 2'd0);
    chk(rsp_cause == 4'd1, "R5", "fetch miss", {28'd0, rsp_cause}, 32'd1);

    ctx = "R6 privilege";
    lookup(32'hD000_0000, 2'd0, 2'd1);
    chk(rsp_cause == 4'd7, "R6", "data priv", {28'd0, rsp_cause}, 32'd7);
    lookup(32'hD000_0000, 2'd2, 2'd3);

    ctx = "R10 array select";
    write(0, 0, 32'h0000_5000, 32'h1234_5000, 8'd1, 4'd1);
    lookup(32'h0000_5abc, 2'd2, 2'd0);
    chk(rsp_cause == 4'd0 && rsp_paddr == 32'h1234_5abc, "R10", "exec uses instr array",
        rsp_paddr, 32'h1234_5abc);
    lookup(32'h0000_5abc, 2'd0, 2'd0);
    chk(rsp_cause == 4'd5, "R10", "read uses data array", {28'd0, rsp_cause}, 32'd5);

    ctx = "R3 asid zero";
    write(1, 1, 32'h0000_6000, 32'h0000_A000, 8'd0, 4'd3);
    set_ids(32'h0403_0100);
    lookup(32'h0000_6010, 2'd0, 2'd0);
    chk(rsp_cause == 4'd5, "R3", "asid 0 ignored", {28'd0, rsp_cause}, 32'd5);
    set_ids(32'h0403_0201);

    ctx = "R2 ring map";
    write(1, 2, 32'h0000_7000, 32'h0004_0000, 8'd5, 4'd3);
    lookup(32'h0000_7008, 2'd0, 2'd0);
    set_ids(32'h0505_0201);
    lookup(32'h0000_7008, 2'd0, 2'd2);
    chk(rsp_cause == 4'd0, "R2", "lowest matching byte is ring 2", {28'd0, rsp_cause}, 32'd0);
    lookup(32'h0000_7008, 2'd1, 2'd3);
    chk(rsp_cause == 4'd7, "R2", "ring 2 below 3", {28'd0, rsp_cause}, 32'd7);
    set_ids(32'h0403_0201);

    ctx = "R4 multi hit";
    write(1, 0, 32'h0000_8000, 32'h0, 8'd1, 4'd3);
    write(1, 3, 32'h0000_8000, 32'h0, 8'd2, 4'd3);
    lookup(32'h0000_8000, 2'd0, 2'd0);
    chk(rsp_cause == 4'd6, "R4", "data multi", {28'd0, rsp_cause}, 32'd6);
    write(0, 1, 32'h0000_5000, 32'h0, 8'd1, 4'd1);
    lookup(32'h0000_5000, 2'd2, 2'd0);
    chk(rsp_cause == 4'd2, "R4", "instr multi", {28'd0, rsp_cause}, 32'd2);

    ctx = "R7 attribute decode";
    for (int a = 0; a < 16; a++) begin
      write(1, 0, 32'h0000_9000, 32'h0009_0000, 8'd1, 4'(a));
      write(0, 0, 32'h0000_9000, 32'h0009_0000, 8'd1, 4'(a));
      lookup(32'h0000_9004, 2'd0, 2'd0);
      lookup(32'h0000_9004, 2'd1, 2'd0);
      lookup(32'h0000_9004, 2'd2, 2'd0);
      lookup(32'h0000_9004, 2'd3, 2'd0);
    end

    ctx = "R8 large page";
    write(1, 4, 32'h0030_0000, 32'h8000_0000, 8'd4, 4'd13);
    lookup(32'h003A_BCDE, 2'd1, 2'd3);
    chk(rsp_paddr == 32'h800A_BCDE, "R8", "1 MiB offset", rsp_paddr, 32'h800A_BCDE);

    ctx = "R11 write with lookup";
    wr_set(1, 0, 32'h0000_C000, 32'h0C00_0000, 8'd1, 4'd3);
    req_valid = 1; req_vaddr = 32'h0000_C123; req_access = 2'd0; req_ring = 2'd0;
    tick();
    wr_en = 0;
    chk(rsp_cause == 4'd5, "R11", "same-cycle write unseen", {28'd0, rsp_cause}, 32'd5);
    tick();
    req_valid = 0;
    chk(rsp_cause == 4'd0, "R11", "write seen next", {28'd0, rsp_cause}, 32'd0);
    rasid_we = 1; rasid_wdata = 32'h0403_0207;
    req_valid = 1; req_vaddr = 32'h0000_C123;
    tick();
    rasid_we = 0; req_valid = 0;
    chk(rsp_cause == 4'd0, "R11", "same-cycle ring-id write unseen", {28'd0, rsp_cause}, 32'd0);
    lookup(32'h0000_C123, 2'd0, 2'd0);
    set_ids(32'h0403_0201);

    ctx = "R1 back-pressure";
    req_valid = 1; req_vaddr = 32'hD000_0040; req_access = 2'd0; req_ring = 2'd0;
    rsp_ready = 0;
    tick();
    req_vaddr = 32'h0000_0040;
    for (int i = 0; i < 4; i++) tick();
    chk(rsp_paddr == 32'h0000_0040, "R1", "held result", rsp_paddr, 32'h0000_0040);
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();

    ctx = "R11 random mix";
    pool[0] = 32'hD000_0123; pool[1] = 32'hE000_0040; pool[2] = 32'h0000_5ABC;
    pool[3] = 32'h0000_6010; pool[4] = 32'h0010_0800; pool[5] = 32'hF800_0004;
    pool[6] = 32'h0000_9004; pool[7] = 32'hD800_7000;
    for (int i = 0; i < 4000; i++) begin
      int w;
      logic [31:0] va;
      req_valid  = ($urandom % 3) != 0;
      req_vaddr  = pool[$urandom % 8];
      req_access = 2'($urandom % 4);
      req_ring   = 2'($urandom % 4);
      rsp_ready  = ($urandom % 4) != 0;
      wr_en = 0; rasid_we = 0;
      if ($urandom % 3 == 0) begin
        w = int'($urandom % 7);
        va = pool[$urandom % 8];
        wr_set($urandom % 2 == 1, w, va, $urandom, 8'($urandom % 6), 4'($urandom));
      end
      if ($urandom % 16 == 0) begin
        rasid_we = 1;
        rasid_wdata = {8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6)};
      end
      tick();
    end
    wr_en = 0; rasid_we = 0; req_valid = 0; rsp_ready = 1;
    tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule